// File: doc/BRIEF.md
# Tiled Depth/Stencil Address and Read-Modify-Write Unit

This block sits between a pixel-level depth/stencil client and a memory port. A command gives a pixel coordinate, a direction (read or write), a target (depth or stencil) and data. The unit adds the window origin to the coordinate and turns it into a byte address. The address is either linear or one of two swizzled tile layouts, one for each depth format. The unit then runs the memory traffic that the access needs and, for reads, returns the value on a response port.

Two storage formats are supported. The first is a plain 16-bit depth halfword. The second is a shared 32-bit word with 24 bits of depth and 8 bits of stencil. In the shared word, a write to one field must leave the other field untouched. The unit does this by reading the word, merging in the new field and writing the word back. A new command is only accepted once the previous one has finished.

Top module: `zs_access_unit`

## Requirements
- R1: In linear mode (`cfg_linear`=1) the request address is B·((x+win_x) + (y+win_y)·pitch), where B is 2 when `cfg_fmt`=0 (16-bit depth) and 4 when `cfg_fmt`=1 (packed 24/8). Word requests are 4-byte aligned and halfword requests are 2-byte aligned.
- R2: In tiled mode with `cfg_fmt`=1, let ex=x+win_x and ey=y+win_y, and let tile index T=(ey/16)·(pitch/16)+ex/16. The address bits are: [1:0]=0, [4:2]=ex[2:0], [6:5]=ey[1:0], [7]=ex[4]^ey[2], [9:8]=T[1:0], [10]=ey[3], [11]=ex[3]^ey[4], and bits 12 upward hold T[2] upward.
- R3: In tiled mode with `cfg_fmt`=0, T=(ey/16)·(pitch/32)+ex/32. The address bits are: [0]=0, [3:1]=ex[2:0], [6:4]=ey[2:0], [7]=ex[3], [9:8]=T[1:0], [10]=ey[3], [11]=ex[4]^ey[4], and bits 12 upward hold T[2] upward.
- R4: The window origin (`win_x`, `win_y`) is added to the command coordinate before any address mapping. A nonzero origin gives the same address as the summed coordinate with a zero origin.
- R5: A packed-format depth write first issues one word read at the address. It then issues one word write that keeps bits [31:24] of the read word and puts `cmd_wdata[23:0]` into bits [23:0].
- R6: A packed-format stencil write first issues one word read. It then issues one word write that keeps bits [23:0] of the read word and puts `cmd_wdata[7:0]` into bits [31:24].
- R7: A packed-format depth read returns word bits [23:0]. A packed-format stencil read returns word bits [31:24] zero-extended to 24 bits. Both issue exactly one read and no write.
- R8: A 16-bit-format write issues exactly one halfword write (`mem_req_wide`=0) carrying `cmd_wdata[15:0]` in the low half of `mem_req_wdata`, with no read beforehand.
- R9: In 16-bit format `cmd_stencil` has no effect. A read returns the halfword zero-extended, and a write behaves as in R8.
- R10: `cmd_ready` is low from the cycle after a command is accepted until its final memory write has been accepted or its response has been given.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request (valid, write, wide, address, data) holds steady.
- R12: After reset `cmd_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0.
- R13: Every read command produces exactly one single-cycle `rsp_valid` pulse. Write commands produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 1 | 0 = 16-bit depth, 1 = packed 24-bit depth + 8-bit stencil |
| cfg_linear | input | 1 | 1 = linear addressing, 0 = tiled |
| cfg_pitch | input | PITCH_W | Surface pitch in pixels |
| win_x | input | COORD_W | Window origin X |
| win_y | input | COORD_W | Window origin Y |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_stencil | input | 1 | 1 = stencil field (packed format only) |
| cmd_x | input | COORD_W | Pixel X |
| cmd_y | input | COORD_W | Pixel Y |
| cmd_wdata | input | 24 | Depth value, or stencil in bits [7:0] |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write request |
| mem_req_wide | output | 1 | 1 = 32-bit word, 0 = 16-bit halfword |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 32 | Write data, halfword in bits [15:0] |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data, halfword in bits [15:0] |
| rsp_valid | output | 1 | Read result pulse |
| rsp_data | output | 24 | Read result |

## Verification
The bench builds the unit with its defaults: 12-bit coordinates, 12-bit pitch, 32-bit addresses and the tiled mapping generated. This is enough width for summed coordinates to cross bits 2, 3 and 4 and to give tile indices whose bits 2 and above reach address bit 12 and beyond. Pitches of 256 and 512 are used so that the tile-row term in the index is exercised in both tiled layouts. A memory model with optional back-pressure holds requests over several cycles, which reaches the stall behaviour in the read and write phases of the read-modify-write.

// File: rtl/zs_pkg.sv
package zs_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned DEPTH_W = 24;
   localparam int unsigned STEN_W  = 8;
   localparam int unsigned HALF_W  = 16;

   typedef enum logic {
      ZS_FMT_Z16   = 1'b0,
      ZS_FMT_Z24S8 = 1'b1
   } zs_fmt_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WAIT = 3'd2,
      ST_WR   = 3'd3,
      ST_RESP = 3'd4
   } zs_state_e;

endpackage

// File: rtl/zs_addr_gen.sv
module zs_addr_gen
   import zs_pkg::*;
#(
   parameter int unsigned COORD_W  = 12,
   parameter int unsigned PITCH_W  = 12,
   parameter int unsigned ADDR_W   = 32,
   parameter bit          TILED_EN = 1'b1
) (
   input  logic                fmt_wide,
   input  logic                linear,
   input  logic [PITCH_W-1:0]  pitch,
   input  logic [COORD_W-1:0]  org_x,
   input  logic [COORD_W-1:0]  org_y,
   input  logic [COORD_W-1:0]  pix_x,
   input  logic [COORD_W-1:0]  pix_y,
   output logic [ADDR_W-1:0]   byte_addr
);

   localparam int unsigned BLK_W = ADDR_W - 10;

   logic [ADDR_W-1:0] ex, ey, pw;
   logic [ADDR_W-1:0] lin_pix, lin_addr, tile_addr;

   assign ex = ADDR_W'(pix_x) + ADDR_W'(org_x);
   assign ey = ADDR_W'(pix_y) + ADDR_W'(org_y);
   assign pw = ADDR_W'(pitch);

   assign lin_pix  = ex + (ey * pw);
   assign lin_addr = fmt_wide ? (lin_pix << 2) : (lin_pix << 1);

   generate
      if (TILED_EN) begin : g_tiled
         logic [BLK_W-1:0]  blk_w, blk_h;
         logic [ADDR_W-1:0] t_word, t_half;

         assign blk_w = BLK_W'(((ey >> 4) * (pw >> 4)) + (ex >> 4));
         assign blk_h = BLK_W'(((ey >> 4) * (pw >> 5)) + (ex >> 5));

         assign t_word = {blk_w[BLK_W-1:2], ex[3] ^ ey[4], ey[3], blk_w[1:0],
                          ex[4] ^ ey[2], ey[1:0], ex[2:0], 2'b00};
         assign t_half = {blk_h[BLK_W-1:2], ex[4] ^ ey[4], ey[3], blk_h[1:0],
                          ex[3], ey[2:0], ex[2:0], 1'b0};

         assign tile_addr = fmt_wide ? t_word : t_half;
      end else begin : g_linear_only
         assign tile_addr = lin_addr;
      end
   endgenerate

   assign byte_addr = linear ? lin_addr : tile_addr;

endmodule

// File: rtl/zs_word_merge.sv
module zs_word_merge
   import zs_pkg::*;
(
   input  logic [WORD_W-1:0]  old_word,
   input  logic [DEPTH_W-1:0] new_val,
   input  logic               fmt_wide,
   input  logic               sel_sten,
   output logic [WORD_W-1:0]  merged_word,
   output logic [DEPTH_W-1:0] read_val
);

   always_comb begin
      if (sel_sten)
         merged_word = {new_val[STEN_W-1:0], old_word[DEPTH_W-1:0]};
      else
         merged_word = {old_word[WORD_W-1:DEPTH_W], new_val};
   end

   always_comb begin
      if (!fmt_wide)
         read_val = {{(DEPTH_W-HALF_W){1'b0}}, old_word[HALF_W-1:0]};
      else if (sel_sten)
         read_val = {{(DEPTH_W-STEN_W){1'b0}}, old_word[WORD_W-1:DEPTH_W]};
      else
         read_val = old_word[DEPTH_W-1:0];
   end

endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
   import zs_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic               cmd_write,
   input  logic               cmd_sten,
   input  logic               cmd_wide,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [DEPTH_W-1:0] cmd_data,
   output logic               op_sten,
   output logic               op_wide,
   output logic [DEPTH_W-1:0] op_data,
   input  logic [WORD_W-1:0]  merged_word,
   input  logic [DEPTH_W-1:0] read_val,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_write,
   output logic               mem_req_wide,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [WORD_W-1:0]  mem_req_wdata,
   input  logic               mem_rsp_valid,
   output logic               rsp_valid,
   output logic [DEPTH_W-1:0] rsp_data
);

   zs_state_e         state;
   logic              op_write;
   logic [ADDR_W-1:0] op_addr;
   logic [WORD_W-1:0] wbuf;
   logic [DEPTH_W-1:0] rsp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_write <= 1'b0;
         op_sten  <= 1'b0;
         op_wide  <= 1'b0;
         op_addr  <= '0;
         op_data  <= '0;
         wbuf     <= '0;
         rsp_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               op_write <= cmd_write;
               op_sten  <= cmd_sten;
               op_wide  <= cmd_wide;
               op_addr  <= cmd_addr;
               op_data  <= cmd_data;
               if (cmd_write && !cmd_wide) begin
                  wbuf  <= {{(WORD_W-HALF_W){1'b0}}, cmd_data[HALF_W-1:0]};
                  state <= ST_WR;
               end else begin
                  state <= ST_RD;
               end
            end
            ST_RD:   if (mem_req_ready) state <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               if (op_write) begin
                  wbuf  <= merged_word;
                  state <= ST_WR;
               end else begin
                  rsp_q <= read_val;
                  state <= ST_RESP;
               end
            end
            ST_WR:   if (mem_req_ready) state <= ST_IDLE;
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready     = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_RD) || (state == ST_WR);
   assign mem_req_write = (state == ST_WR);
   assign mem_req_wide  = op_wide;
   assign mem_req_addr  = op_addr;
   assign mem_req_wdata = wbuf;
   assign rsp_valid     = (state == ST_RESP);
   assign rsp_data      = rsp_q;

endmodule

// File: rtl/zs_access_unit.sv
module zs_access_unit
   import zs_pkg::*;
#(
   parameter int unsigned COORD_W  = 12,
   parameter int unsigned PITCH_W  = 12,
   parameter int unsigned ADDR_W   = 32,
   parameter bit          TILED_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_fmt,
   input  logic                cfg_linear,
   input  logic [PITCH_W-1:0]  cfg_pitch,
   input  logic [COORD_W-1:0]  win_x,
   input  logic [COORD_W-1:0]  win_y,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic                cmd_write,
   input  logic                cmd_stencil,
   input  logic [COORD_W-1:0]  cmd_x,
   input  logic [COORD_W-1:0]  cmd_y,
   input  logic [23:0]         cmd_wdata,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic                mem_req_write,
   output logic                mem_req_wide,
   output logic [ADDR_W-1:0]   mem_req_addr,
   output logic [31:0]         mem_req_wdata,
   input  logic                mem_rsp_valid,
   input  logic [31:0]         mem_rsp_data,
   output logic                rsp_valid,
   output logic [23:0]         rsp_data
);

   if (COORD_W < 5) begin : g_bad_coord
      $error("zs_access_unit: COORD_W must be at least 5");
   end
   if (ADDR_W < COORD_W + PITCH_W + 4) begin : g_bad_addr
      $error("zs_access_unit: ADDR_W too narrow for linear addressing");
   end
   if (ADDR_W < 16) begin : g_bad_tile
      $error("zs_access_unit: ADDR_W must be at least 16");
   end

   logic               wide;
   logic               eff_sten;
   logic [ADDR_W-1:0]  calc_addr;
   logic               op_sten, op_wide;
   logic [DEPTH_W-1:0] op_data;
   logic [WORD_W-1:0]  merged_word;
   logic [DEPTH_W-1:0] read_val;

   assign wide     = (zs_fmt_e'(cfg_fmt) == ZS_FMT_Z24S8);
   assign eff_sten = cmd_stencil && wide;

   zs_addr_gen #(
      .COORD_W  (COORD_W),
      .PITCH_W  (PITCH_W),
      .ADDR_W   (ADDR_W),
      .TILED_EN (TILED_EN)
   ) u_addr (
      .fmt_wide  (wide),
      .linear    (cfg_linear),
      .pitch     (cfg_pitch),
      .org_x     (win_x),
      .org_y     (win_y),
      .pix_x     (cmd_x),
      .pix_y     (cmd_y),
      .byte_addr (calc_addr)
   );

   zs_word_merge u_merge (
      .old_word    (mem_rsp_data),
      .new_val     (op_data),
      .fmt_wide    (op_wide),
      .sel_sten    (op_sten),
      .merged_word (merged_word),
      .read_val    (read_val)
   );

   zs_ctrl #(
      .ADDR_W (ADDR_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_write     (cmd_write),
      .cmd_sten      (eff_sten),
      .cmd_wide      (wide),
      .cmd_addr      (calc_addr),
      .cmd_data      (cmd_wdata),
      .op_sten       (op_sten),
      .op_wide       (op_wide),
      .op_data       (op_data),
      .merged_word   (merged_word),
      .read_val      (read_val),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_wide  (mem_req_wide),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_valid     (rsp_valid),
      .rsp_data      (rsp_data)
   );

endmodule

// File: rtl/zs_access_chk.sv
module zs_access_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic              mem_req_wide,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [31:0]       mem_req_wdata,
   input logic              mem_rsp_valid,
   input logic              rsp_valid
);

   logic got_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         got_read <= 1'b0;
      else if (mem_req_valid && mem_req_ready && mem_req_write)
         got_read <= 1'b0;
      else if (mem_rsp_valid)
         got_read <= 1'b1;
   end

   // R1
   align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_wide ? (mem_req_addr[1:0] == 2'b00) : (mem_req_addr[0] == 1'b0)));

   // R5
   rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && mem_req_wide) |-> got_read);

   // R10
   busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || rsp_valid) |-> !cmd_ready);

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
          && $stable(mem_req_wide) && $stable(mem_req_wdata)));

   // R13
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind zs_access_unit zs_access_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_wide  (mem_req_wide),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .mem_rsp_valid (mem_rsp_valid),
   .rsp_valid     (rsp_valid)
);

// File: tb/tb_zs_access_unit.sv
`timescale 1ns/1ps
module tb_zs_access_unit;

   localparam int CW = 12;
   localparam int PW = 12;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_fmt = 1'b0, cfg_linear = 1'b0;
   logic [PW-1:0] cfg_pitch = '0;
   logic [CW-1:0] win_x = '0, win_y = '0;
   logic          cmd_valid = 1'b0, cmd_write = 1'b0, cmd_stencil = 1'b0;
   logic [CW-1:0] cmd_x = '0, cmd_y = '0;
   logic [23:0]   cmd_wdata = '0;
   logic          cmd_ready;
   logic          mem_req_valid, mem_req_write, mem_req_wide;
   logic          mem_req_ready;
   logic [AW-1:0] mem_req_addr;
   logic [31:0]   mem_req_wdata;
   logic          mem_rsp_valid = 1'b0;
   logic [31:0]   mem_rsp_data = '0;
   logic          rsp_valid;
   logic [23:0]   rsp_data;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   zs_access_unit #(.COORD_W(CW), .PITCH_W(PW), .ADDR_W(AW), .TILED_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_linear(cfg_linear),
      .cfg_pitch(cfg_pitch), .win_x(win_x), .win_y(win_y),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_stencil(cmd_stencil), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_wdata(cmd_wdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_wide(mem_req_wide),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   // memory model
   bit [7:0]  mem [bit [31:0]];
   int        n_rd = 0, n_wr = 0;
   bit [31:0] last_waddr, last_raddr, last_wdata;
   bit        last_wwide;
   bit        stall_en = 1'b0;
   bit [1:0]  stall_cnt = '0;

   assign mem_req_ready = !stall_en || (stall_cnt == 2'd3);

   always @(posedge clk) begin
      stall_cnt     <= stall_cnt + 2'd1;
      mem_rsp_valid <= 1'b0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            mem[mem_req_addr]     = mem_req_wdata[7:0];
            mem[mem_req_addr + 1] = mem_req_wdata[15:8];
            if (mem_req_wide) begin
               mem[mem_req_addr + 2] = mem_req_wdata[23:16];
               mem[mem_req_addr + 3] = mem_req_wdata[31:24];
            end
            last_waddr <= mem_req_addr;
            last_wdata <= mem_req_wdata;
            last_wwide <= mem_req_wide;
            n_wr       <= n_wr + 1;
         end else begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_req_wide ?
               {mem[mem_req_addr+3], mem[mem_req_addr+2], mem[mem_req_addr+1], mem[mem_req_addr]} :
               {16'h0, mem[mem_req_addr+1], mem[mem_req_addr]};
            last_raddr <= mem_req_addr;
            n_rd       <= n_rd + 1;
         end
      end
   end

   task automatic put_word(input bit [31:0] a, input bit [31:0] v);
      mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
   endtask

   function automatic bit [31:0] get_word(input bit [31:0] a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // independent address model built bit by bit from the requirement text
   function automatic bit [31:0] exp_addr(input bit fmt, input bit lin, input int pitch,
                                          input int x, input int y);
      int ex = x + int'(win_x);
      int ey = y + int'(win_y);
      bit [31:0] e, f, t, a;
      e = ex; f = ey;
      if (lin) return (fmt ? 4 : 2) * (ex + ey * pitch);
      a = '0;
      if (fmt) begin
         t = (ey / 16) * (pitch / 16) + ex / 16;
         for (int i = 0; i < 3; i++) a[2+i] = e[i];
         for (int i = 0; i < 2; i++) a[5+i] = f[i];
         a[7]  = e[4] ^ f[2];
         a[11] = e[3] ^ f[4];
      end else begin
         t = (ey / 16) * (pitch / 32) + ex / 32;
         for (int i = 0; i < 3; i++) a[1+i] = e[i];
         for (int i = 0; i < 3; i++) a[4+i] = f[i];
         a[7]  = e[3];
         a[11] = e[4] ^ f[4];
      end
      a[8] = t[0]; a[9] = t[1]; a[10] = f[3];
      for (int i = 12; i < 32; i++) a[i] = t[i-10];
      return a;
   endfunction

   task automatic run_cmd(input bit wr, input bit st, input int x, input int y,
                          input bit [23:0] d, output bit [23:0] rd,
                          output int nrsp, output int nr, output int nw, output bit busy);
      int r0 = n_rd;
      int w0 = n_wr;
      int guard = 0;
      nrsp = 0; rd = '0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_stencil = st;
      cmd_x = CW'(x); cmd_y = CW'(y); cmd_wdata = d;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      busy = !cmd_ready;
      while (!cmd_ready && guard < 1000) begin
         if (rsp_valid) begin nrsp++; rd = rsp_data; end
         @(negedge clk);
         guard++;
      end
      if (guard >= 1000) check(1'b0, "R10", "command never completed", guard, 0);
      nr = n_rd - r0;
      nw = n_wr - w0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(cmd_ready === 1'b1, "R12", "cmd_ready after reset", cmd_ready, 1);
      check(mem_req_valid === 1'b0, "R12", "mem_req_valid after reset", mem_req_valid, 0);
      check(rsp_valid === 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);
   endtask

   // R1 R5 R6 R7 packed linear
   task automatic t_packed_linear();
      bit [23:0] rd; int nrsp, nr, nw; bit busy; bit [31:0] a;
      cfg_fmt = 1; cfg_linear = 1; cfg_pitch = 64; win_x = 0; win_y = 0;
      a = exp_addr(1, 1, 64, 5, 3);
      put_word(a, 32'hAB11_2233);
      run_cmd(1, 0, 5, 3, 24'h44_5566, rd, nrsp, nr, nw, busy);
      check(last_waddr == a, "R1", "linear packed address", last_waddr, a);
      check(nr == 1 && nw == 1, "R5", "depth write read+write count", nr*16+nw, 17);
      check(get_word(a) == 32'hAB44_5566, "R5", "depth write keeps stencil", get_word(a), 32'hAB445566);
      check(nrsp == 0, "R13", "no response on write", nrsp, 0);
      check(busy, "R10", "busy after accept", busy, 1);
      run_cmd(1, 1, 5, 3, 24'h00_00C3, rd, nrsp, nr, nw, busy);
      check(get_word(a) == 32'hC344_5566, "R6", "stencil write keeps depth", get_word(a), 32'hC3445566);
      run_cmd(0, 1, 5, 3, 24'h0, rd, nrsp, nr, nw, busy);
      check(rd == 24'h0000C3 && nrsp == 1, "R7", "stencil read value", rd, 24'hC3);
      check(nr == 1 && nw == 0, "R7", "read issues one read only", nr*16+nw, 16);
      run_cmd(0, 0, 5, 3, 24'h0, rd, nrsp, nr, nw, busy);
      check(rd == 24'h44_5566 && nrsp == 1, "R7", "depth read value", rd, 24'h445566);
      check(last_raddr == a, "R1", "read address", last_raddr, a);
   endtask

   // R2 R4 R6 tiled 32-bit
   task automatic t_tiled_word();
      bit [23:0] rd; int nrsp, nr, nw; bit busy; bit [31:0] a;
      int xs [6] = '{0, 8, 16, 31, 100, 2000};
      int ys [6] = '{0, 16, 4, 31, 77, 1500};
      cfg_fmt = 1; cfg_linear = 0; cfg_pitch = 256;
      for (int k = 0; k < 6; k++) begin
         win_x = (k > 2) ? 12'd17 : 12'd0;
         win_y = (k > 2) ? 12'd9  : 12'd0;
         a = exp_addr(1, 0, 256, xs[k], ys[k]);
         put_word(a, 32'h00AB_CDEF);
         run_cmd(1, 1, xs[k], ys[k], 24'h5A, rd, nrsp, nr, nw, busy);
         check(last_waddr == a, (k > 2) ? "R4" : "R2", "tiled word address", last_waddr, a);
         check(get_word(a) == 32'h5AAB_CDEF, "R6", "stencil merge", get_word(a), 32'h5AABCDEF);
      end
      // origin equivalence: (20,30)+(17,9) vs (37,39)+0
      win_x = 17; win_y = 9;
      run_cmd(0, 0, 20, 30, 0, rd, nrsp, nr, nw, busy);
      a = last_raddr;
      win_x = 0; win_y = 0;
      run_cmd(0, 0, 37, 39, 0, rd, nrsp, nr, nw, busy);
      check(last_raddr == a, "R4", "origin adds to coordinate", last_raddr, a);
   endtask

   // R3 R8 R9 tiled 16-bit, R1 linear 16-bit
   task automatic t_half();
      bit [23:0] rd; int nrsp, nr, nw; bit busy; bit [31:0] a;
      int xs [5] = '{0, 8, 16, 45, 900};
      int ys [5] = '{0, 3, 16, 29, 611};
      cfg_fmt = 0; cfg_linear = 0; cfg_pitch = 512; win_x = 3; win_y = 5;
      for (int k = 0; k < 5; k++) begin
         a = exp_addr(0, 0, 512, xs[k], ys[k]);
         run_cmd(1, k[0], xs[k], ys[k], 24'hFF_1234 + 24'(k), rd, nrsp, nr, nw, busy);
         check(last_waddr == a, "R3", "tiled half address", last_waddr, a);
         check(nr == 0 && nw == 1 && !last_wwide, "R8", "single half write", nr*16+nw, 1);
         check(last_wdata[15:0] == 16'h1234 + 16'(k), "R8", "half write data",
               last_wdata[15:0], 16'h1234 + 16'(k));
         run_cmd(0, 1, xs[k], ys[k], 0, rd, nrsp, nr, nw, busy);
         check(rd == 24'h001234 + 24'(k) && nrsp == 1, "R9", "half read ignores stencil flag",
               rd, 24'h1234 + 24'(k));
      end
      cfg_linear = 1; cfg_pitch = 100;
      a = exp_addr(0, 1, 100, 7, 2);
      run_cmd(1, 0, 7, 2, 24'h00_BEEF, rd, nrsp, nr, nw, busy);
      check(last_waddr == a, "R1", "linear half address", last_waddr, a);
   endtask

   // R11 R5 under back-pressure
   task automatic t_stall();
      bit [23:0] rd; int nrsp, nr, nw; bit busy; bit [31:0] a;
      stall_en = 1; cfg_fmt = 1; cfg_linear = 0; cfg_pitch = 256; win_x = 0; win_y = 0;
      a = exp_addr(1, 0, 256, 50, 60);
      put_word(a, 32'h7700_0000);
      run_cmd(1, 0, 50, 60, 24'h12_3456, rd, nrsp, nr, nw, busy);
      check(get_word(a) == 32'h7712_3456 && nr == 1 && nw == 1, "R11",
            "stalled read-modify-write result", get_word(a), 32'h77123456);
      run_cmd(0, 0, 50, 60, 0, rd, nrsp, nr, nw, busy);
      check(rd == 24'h12_3456 && nrsp == 1, "R13", "stalled read single response", nrsp, 1);
      stall_en = 0;
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_packed_linear();
      t_tiled_word();
      t_half();
      t_stall();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule